// File: doc/BRIEF.md
# Banked Per-Core Timer Window Decoder

This block holds one private countdown timer for each core of a cluster and routes register traffic to them. The register space is split into windows of 0x20 bytes. Window 0 is a banked alias: the access goes to the timer whose index equals the ID of the core making the request. Each core can therefore reach its own timer at one shared address. Window k+1 always reaches the timer of core k, whichever core issues the access. This lets one core inspect or program another core's timer.

Each timer has a reload register, a live counter, a control register and a sticky status flag. Each drives its own interrupt line, and the lines are packed by core index. A request is a single-cycle strobe. Read data is returned combinationally in the same cycle, and writes take effect at the next clock edge. The core count is a parameter from 1 up to a fixed maximum of 8. Reset is synchronous and active high, and it clears every timer.

Top module: `bank_timer`

## Requirements
- R1: During reset and in the first cycle after it, every interrupt line is low and every timer register reads as zero.
- R2: An access to window k+1 (1 <= k+1 <= N_CORES) reaches timer k whatever the value of `req_core`.
- R3: An access to window 0 reaches the timer whose index equals `req_core`.
- R4: An access to window 0 with `req_core` >= N_CORES raises `alias_err` in the same cycle, reads zero and changes no timer.
- R5: An access to a window above N_CORES reads zero, changes no timer and leaves `alias_err` low.
- R6: Only 32-bit accesses are accepted: with `req_word` low, or with `req_off[1:0]` not zero, a request reads zero and changes nothing.
- R7: Byte offsets are 0x0 for reload, 0x4 for counter, 0x8 for control (bit 0 run, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescale, other bits read zero) and 0xC for status (bit 0). Offsets 0x10 to 0x1C read zero. Read data appears in the cycle of a read request; it is zero on writes and when no request is present.
- R8: A write to reload sets both reload and counter. A write to counter sets only the counter.
- R9: While run is set, the timer ticks once every prescale+1 clocks, with the prescale phase restarting at zero on each control write. A tick on a non-zero counter decrements it. A tick that takes it from 1 to 0 sets status, and then the counter is reloaded if auto-reload is set or stays at 0 if not.
- R10: A status write with bit 0 set clears the status flag, unless the same cycle's tick sets it again, in which case the set wins.
- R11: `irq[k]` is the status flag of timer k ANDed with its interrupt enable.
- R12: A write changes only the timer it selects; all other timers keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access |
| req_core | input | 3 | ID of the requesting core |
| req_win | input | 4 | Window select (0 = banked alias) |
| req_off | input | 5 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle |
| alias_err | output | 1 | Alias access from a core with no timer |
| irq | output | N_CORES | Interrupt lines, bit k for core k |

## Verification
The bench targets the routing corners. A decoder that ignored `req_core` on the alias would read and write one fixed timer, and one that skipped the `-1` on direct windows would land one timer off. Alias requests from core IDs 4 to 7 and windows 5 to 15 test the guards: a design that wrapped the index would corrupt a real timer, and one that let window overflow raise the error flag would show `alias_err` where it should stay low. Counting is checked with auto-reload at load 1 and with a status clear on the exact cycle of a tick. A design that let the clear win would drop the interrupt for one cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int MAX_CORES = 8;
    localparam int CORE_W    = $clog2(MAX_CORES);
    localparam int WIN_W     = $clog2(MAX_CORES + 2);
    localparam int OFF_W     = 5;
    localparam int DATA_W    = 32;
    localparam int PRE_W     = 8;

    typedef enum logic [2:0] {
        FLD_RELOAD = 3'd0,
        FLD_COUNT  = 3'd1,
        FLD_CTRL   = 3'd2,
        FLD_STATUS = 3'd3
    } field_e;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             irq_en;
        logic             auto_rl;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        field_e            field;
        logic [DATA_W-1:0] wdata;
    } wr_req_t;

    function automatic ctrl_t ctrl_from_word(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.presc   = w[15:8];
        c.irq_en  = w[2];
        c.auto_rl = w[1];
        c.run     = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[15:8]  = c.presc;
        w[2]     = c.irq_en;
        w[1]     = c.auto_rl;
        w[0]     = c.run;
        return w;
    endfunction

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              valid,
    input  logic              word,
    input  logic [CORE_W-1:0] core,
    input  logic [WIN_W-1:0]  win,
    input  logic [OFF_W-1:0]  off,
    output logic [N-1:0]      sel,
    output logic              err,
    output field_e            field
);

    logic aligned;
    logic is_alias;
    logic tgt_ok;
    int   tgt;

    always_comb begin
        aligned  = word && (off[1:0] == 2'b00);
        is_alias = (win == '0);
        if (is_alias) begin
            tgt    = int'(core);
            tgt_ok = int'(core) < N;
        end else begin
            tgt    = int'(win) - 1;
            tgt_ok = int'(win) <= N;
        end
        err   = valid && is_alias && (int'(core) >= N);
        field = field_e'(off[4:2]);
    end

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = valid && aligned && tgt_ok && (tgt == i);
    end

endmodule

// File: rtl/bt_timer.sv
module bt_timer
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wreq,
    input  field_e            rfield,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [DATA_W-1:0] reload_q, count_q, count_d;
    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  phase_q, phase_d;
    logic              stat_q, stat_d;
    logic              tick, fire;
    logic              wr_reload, wr_count, wr_ctrl, wr_stat;

    always_comb begin
        wr_reload = wreq.wr && (wreq.field == FLD_RELOAD);
        wr_count  = wreq.wr && (wreq.field == FLD_COUNT);
        wr_ctrl   = wreq.wr && (wreq.field == FLD_CTRL);
        wr_stat   = wreq.wr && (wreq.field == FLD_STATUS);

        tick = ctrl_q.run && (phase_q == ctrl_q.presc);
        if (!ctrl_q.run || wr_ctrl || tick) phase_d = '0;
        else                                phase_d = phase_q + 1'b1;

        fire    = 1'b0;
        count_d = count_q;
        if (tick && count_q != '0) begin
            if (count_q == DATA_W'(1)) begin
                fire    = 1'b1;
                count_d = ctrl_q.auto_rl ? reload_q : '0;
            end else begin
                count_d = count_q - 1'b1;
            end
        end
        if (wr_reload || wr_count) count_d = wreq.wdata;

        if (fire)                         stat_d = 1'b1;
        else if (wr_stat && wreq.wdata[0]) stat_d = 1'b0;
        else                              stat_d = stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            phase_q  <= '0;
            stat_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wreq.wdata;
            if (wr_ctrl)   ctrl_q   <= ctrl_from_word(wreq.wdata);
            count_q <= count_d;
            phase_q <= phase_d;
            stat_q  <= stat_d;
        end
    end

    always_comb begin
        case (rfield)
            FLD_RELOAD: rdata = reload_q;
            FLD_COUNT:  rdata = count_q;
            FLD_CTRL:   rdata = ctrl_to_word(ctrl_q);
            FLD_STATUS: rdata = {{(DATA_W-1){1'b0}}, stat_q};
            default:    rdata = '0;
        endcase
    end

    assign irq = stat_q && ctrl_q.irq_en;

endmodule

// File: rtl/bt_rdmux.sv
module bt_rdmux
    import bt_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]             sel,
    input  logic                     rd_en,
    input  logic [N-1:0][DATA_W-1:0] rd_in,
    output logic [DATA_W-1:0]        rd_out
);

    logic [N:0][DATA_W-1:0] acc;

    assign acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign acc[i+1] = acc[i] | ((sel[i] && rd_en) ? rd_in[i] : '0);
    end

    assign rd_out = acc[N];

endmodule

// File: rtl/bank_timer.sv
module bank_timer
    import bt_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic                 req_word,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [WIN_W-1:0]     req_win,
    input  logic [OFF_W-1:0]     req_off,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 alias_err,
    output logic [N_CORES-1:0]   irq
);

    logic [N_CORES-1:0]             sel;
    field_e                         field;
    logic [N_CORES-1:0][DATA_W-1:0] trd;

    bt_decode #(.N(N_CORES)) u_dec (
        .valid (req_valid),
        .word  (req_word),
        .core  (req_core),
        .win   (req_win),
        .off   (req_off),
        .sel   (sel),
        .err   (alias_err),
        .field (field)
    );

    for (genvar i = 0; i < N_CORES; i++) begin : g_tmr
        wr_req_t wq;
        assign wq.wr    = sel[i] && req_we;
        assign wq.field = field;
        assign wq.wdata = req_wdata;

        bt_timer u_tmr (
            .clk    (clk),
            .rst    (rst),
            .wreq   (wq),
            .rfield (field),
            .rdata  (trd[i]),
            .irq    (irq[i])
        );
    end

    bt_rdmux #(.N(N_CORES)) u_mux (
        .sel    (sel),
        .rd_en  (!req_we),
        .rd_in  (trd),
        .rd_out (rd_data)
    );

endmodule

// File: rtl/bt_check.sv
module bt_check
    import bt_pkg::*;
#(
    parameter int N = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_word,
    input logic              req_we,
    input logic [OFF_W-1:0]  req_off,
    input logic [DATA_W-1:0] rd_data,
    input logic              alias_err,
    input logic [N-1:0]      irq,
    input logic [N-1:0]      sel
);

    assert_alias_err_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        alias_err |-> (rd_data == '0 && sel == '0));

    assert_single_target_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    assert_narrow_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!req_word || req_off[1:0] != 2'b00)) |-> (rd_data == '0 && sel == '0));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (rd_data == '0 && !alias_err));

    assert_irq_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0));

    for (genvar i = 0; i < N; i++) begin : g_irq
        assert_irq_drop_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[i]) |-> $past(req_valid && req_we));
    end

endmodule

bind bank_timer bt_check #(.N(N_CORES)) u_chk (.*);

// File: tb/bank_timer_test.sv
module bank_timer_test;
    import bt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_we = 1'b0;
    logic                 req_word = 1'b1;
    logic [CORE_W-1:0]    req_core = '0;
    logic [WIN_W-1:0]     req_win = '0;
    logic [OFF_W-1:0]     req_off = '0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic [DATA_W-1:0]    rd_data;
    logic                 alias_err;
    logic [N-1:0]         irq;

    int total = 0;
    int bad = 0;

    logic [31:0] m_load [N];
    logic [31:0] m_cnt  [N];
    logic [31:0] m_ctl  [N];
    logic        m_st   [N];
    int          m_ph   [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_timer #(.N_CORES(N)) uut (.*);

    function automatic int target(int core, int win);
        if (win == 0) return (core < N) ? core : -1;
        return (win <= N) ? win - 1 : -1;
    endfunction

    function automatic bit accepted();
        return req_valid && req_word && (req_off % 4 == 0) &&
               target(int'(req_core), int'(req_win)) >= 0;
    endfunction

    // reference state update on every edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_load[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; m_st[i] = 0; m_ph[i] = 0;
            end
        end else begin
            int t;
            int fld;
            t   = accepted() && req_we ? target(int'(req_core), int'(req_win)) : -1;
            fld = int'(req_off) / 4;
            for (int i = 0; i < N; i++) begin
                bit run, tk, ev;
                run = m_ctl[i][0];
                tk  = run && (m_ph[i] == int'(m_ctl[i][15:8]));
                ev  = 0;
                if (tk && m_cnt[i] != 0) begin
                    if (m_cnt[i] == 1) begin
                        ev = 1;
                        m_cnt[i] = m_ctl[i][1] ? m_load[i] : 0;
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
                if (!run || tk || (t == i && fld == 2)) m_ph[i] = 0;
                else m_ph[i] = m_ph[i] + 1;
                if (t == i) begin
                    case (fld)
                        0: begin m_load[i] = req_wdata; m_cnt[i] = req_wdata; end
                        1: m_cnt[i] = req_wdata;
                        2: m_ctl[i] = req_wdata & 32'h0000_FF07;
                        3: if (req_wdata[0]) m_st[i] = 0;
                        default: ;
                    endcase
                end
                if (ev) m_st[i] = 1;
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        int t;
        if (!accepted() || req_we) return 0;
        t = target(int'(req_core), int'(req_win));
        case (int'(req_off) / 4)
            0: return m_load[t];
            1: return m_cnt[t];
            2: return m_ctl[t];
            3: return {31'b0, m_st[t]};
            default: return 0;
        endcase
    endfunction

    task automatic compare(string tag);
        logic [N-1:0] ei;
        logic         ee;
        logic [31:0]  er;
        for (int i = 0; i < N; i++) ei[i] = m_st[i] & m_ctl[i][2];
        ee = req_valid && req_win == 0 && int'(req_core) >= N;
        er = exp_rd();
        total++;
        if (rd_data !== er) begin
            bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, er);
        end
        total++;
        if (alias_err !== ee) begin
            bad++;
            $display("FAIL %s alias_err actual=%b expected=%b", tag, alias_err, ee);
        end
        total++;
        if (irq !== ei) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
        end
    endtask

    task automatic cyc(string tag, bit v, bit we, int core, int win, int off,
                       logic [31:0] wd = 0, bit word = 1);
        @(negedge clk);
        req_valid = v; req_we = we; req_core = CORE_W'(core); req_win = WIN_W'(win);
        req_off = OFF_W'(off); req_wdata = wd; req_word = word;
        #1 compare(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int k = 0; k < 3; k++) cyc("R1 in reset", 1, 0, 0, 1, 4 * k);
        @(negedge clk); rst = 0;
        for (int w = 1; w <= N; w++)
            for (int o = 0; o < 16; o += 4) cyc("R1 after reset", 1, 0, 0, w, o);

        // R2: direct windows, foreign core
        for (int w = 1; w <= N; w++) cyc("R2 direct write", 1, 1, 7 - w, w, 0, 32'h100 + w);
        for (int w = 1; w <= N; w++) cyc("R2 direct read", 1, 0, (w + 1) % N, w, 0);

        // R3: alias reaches own timer
        for (int c = 0; c < N; c++) cyc("R3 alias write", 1, 1, c, 0, 4, 32'h200 + c);
        for (int c = 0; c < N; c++) cyc("R3 alias read", 1, 0, c, 0, 4);
        for (int w = 1; w <= N; w++) cyc("R3 direct view", 1, 0, 0, w, 4);

        // R4: alias from core without a timer
        for (int c = N; c < 8; c++) cyc("R4 bad alias write", 1, 1, c, 0, 0, 32'hDEAD);
        for (int c = N; c < 8; c++) cyc("R4 bad alias read", 1, 0, c, 0, 0);

        // R5: windows above the core count
        for (int w = N + 1; w < 16; w++) cyc("R5 high window write", 1, 1, 0, w, 0, 32'hBEEF);
        for (int w = N + 1; w < 16; w++) cyc("R5 high window read", 1, 0, 1, w, 0);

        // R6: narrow or misaligned
        cyc("R6 narrow write", 1, 1, 0, 1, 0, 32'h55, 0);
        cyc("R6 narrow read", 1, 0, 0, 1, 0, 0, 0);
        cyc("R6 misaligned write", 1, 1, 1, 0, 1, 32'h66);
        cyc("R6 misaligned read", 1, 0, 1, 0, 6);

        // R12: other timers untouched after all the above
        for (int w = 1; w <= N; w++)
            for (int o = 0; o < 16; o += 4) cyc("R12 state check", 1, 0, 2, w, o);

        // R7: control field mask and empty offsets
        cyc("R7 ctrl write", 1, 1, 3, 0, 8, 32'hFFFF_FFF8);
        cyc("R7 ctrl read", 1, 0, 3, 0, 8);
        for (int o = 16; o < 32; o += 4) cyc("R7 empty offsets", 1, 0, 3, 0, o);
        cyc("R7 ctrl clear", 1, 1, 3, 4, 8, 0);

        // R8/R9/R11: one-shot on timer 0
        cyc("R8 reload write", 1, 1, 0, 0, 0, 3);
        cyc("R8 count write", 1, 1, 0, 1, 4, 2);
        cyc("R9 one-shot start", 1, 1, 0, 1, 8, 32'h0000_0005);
        idle("R9 one-shot run R11", 6);
        cyc("R9 one-shot count", 1, 0, 0, 0, 4);

        // R9: prescaled auto-reload on timer 1
        cyc("R9 auto reload value", 1, 1, 1, 2, 0, 2);
        cyc("R9 auto start", 1, 1, 1, 2, 8, 32'h0000_0207);
        for (int k = 0; k < 20; k++) cyc("R9 auto count", 1, 0, 1, 0, 4);

        // R10: clear, and clear colliding with a tick
        cyc("R10 clear timer0", 1, 1, 0, 1, 12, 1);
        cyc("R10 after clear", 1, 0, 0, 1, 12);
        cyc("R10 fast reload", 1, 1, 2, 0, 0, 1);
        cyc("R10 fast start", 1, 1, 2, 0, 8, 32'h0000_0007);
        idle("R10 fast run", 3);
        cyc("R10 clear vs set", 1, 1, 2, 0, 12, 1);
        idle("R10 after collide", 2);
        cyc("R11 mask irq", 1, 1, 2, 3, 8, 32'h0000_0003);
        idle("R11 masked", 2);
        cyc("R10 status stays", 1, 0, 2, 3, 12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule